// File: doc/BRIEF.md
# DLL Sampling Phase Programming Sequencer

This block moves a delay-locked-loop sampling clock to a new output phase without producing a glitch. A start strobe and a 4-bit phase index launch a fixed series of updates to a control word that the delay line reads. First the output gate is closed and the loop is taken off automatic clock recovery and put on external selection. Next the requested phase is written in Gray code into a select field. Then the gate is opened again, and only after that is control handed back to automatic recovery.

Each step that opens or closes the gate waits for a status input, which reports the real gate state, to match the new setting. Each of these waits is limited by a poll budget. The budget is counted in microsecond ticks from a prescaler on the system clock. A wait that runs out of budget ends the sequence with an error. The block reports the result with a one-cycle done pulse, and an error flag rides on that same pulse.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset, ctrl_word is all zero and busy, done and err are low.
- R2: In the cycle after an accepted start, ctrl_word holds these values: loop enable (bit 0) = 1, external select (bit 3) = 1, recovery enable (bit 1) = 0, output gate (bit 2) = 0. The select field still holds its previous value.
- R3: The select field is not written while gate_stat reads 1 in the first wait. If gate_stat stays at 1, the select field keeps its old value through the timeout.
- R4: The select field is bits 23:20. It receives the reflected Gray code of phase_idx, which is idx XOR (idx >> 1).
- R5: The select field changes only while the output gate bit is 0. The gate bit is set only after the new select value is in place.
- R6: After the gate bit is set and gate_stat reads 1, recovery enable is set and external select is cleared in the same update. done pulses for one cycle and err stays 0.
- R7: A wait times out when the gate status has not matched for POLL_LIMIT ticks of TICK_DIV clock cycles each, counted from entry into the wait. On timeout, done and err pulse together, ctrl_word is left as it was, and busy drops.
- R8: A start strobe that arrives while busy is high is ignored.
- R9: Every ctrl_word bit outside bits 0 to 3 and the select field stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Strobe that begins a phase change |
| phase_idx | input | PHASE_W | Requested phase, 0 to 15 |
| gate_stat | input | 1 | Observed state of the delay line's output gate |
| ctrl_word | output | CTRL_W | Control word driven to the delay line |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | Pulses with done when a wait timed out |

## Verification
The main function is exercised with a set of phase indices that differ in one bit from their neighbours, that sit at either end of the range, and that include values whose Gray code differs from the binary index in several bits. This separates a correct Gray encoding from a plain binary or shifted load. A gate model with latency makes both waits take several polls. A status line held high and a status line held low produce a timeout at each of the two waits, and the resulting control word shows which step the sequence reached. The exact cycle of each timeout is checked against the tick budget. A start strobe that arrives mid-sequence with a different phase shows whether the strobe leaks into the running sequence.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT_LOW,
      S_LOAD,
      S_REGATE,
      S_WAIT_HIGH
   } seq_state_t;
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   if (DIV < 1) begin : g_bad_div
      $error("us_prescaler: DIV must be at least 1");
   end

   assign tick = !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr)        cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/poll_limiter.sv
module poll_limiter #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] polls_q;

   if (LIMIT < 1) begin : g_bad_limit
      $error("poll_limiter: LIMIT must be at least 1");
   end

   assign expired = tick && (polls_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    polls_q <= '0;
      else if (clr)  polls_q <= '0;
      else if (tick && polls_q != LAST) polls_q <= polls_q + 1'b1;
   end
endmodule

// File: rtl/gray_enc.sv
module gray_enc #(
   parameter int W = 4
) (
   input  logic [W-1:0] bin,
   output logic [W-1:0] gray
);
   if (W < 1) begin : g_bad_w
      $error("gray_enc: W must be at least 1");
   end

   assign gray[W-1] = bin[W-1];
   for (genvar i = 0; i < W - 1; i++) begin : g_bit
      assign gray[i] = bin[i] ^ bin[i+1];
   end
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
   import dll_seq_pkg::*;
#(
   parameter int PHASE_W    = 4,
   parameter int CTRL_W     = 32,
   parameter int SEL_LSB    = 20,
   parameter int EN_POS     = 0,
   parameter int REC_POS    = 1,
   parameter int GATE_POS   = 2,
   parameter int EXT_POS    = 3,
   parameter int TICK_DIV   = 50,
   parameter int POLL_LIMIT = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PHASE_W-1:0] phase_idx,
   input  logic               gate_stat,
   output logic [CTRL_W-1:0]  ctrl_word,
   output logic               busy,
   output logic               done,
   output logic               err
);
   localparam int SEL_MSB = SEL_LSB + PHASE_W - 1;

   if (SEL_MSB >= CTRL_W) begin : g_bad_sel
      $error("dll_phase_seq: select field exceeds control word");
   end
   if (EN_POS >= CTRL_W || REC_POS >= CTRL_W ||
       GATE_POS >= CTRL_W || EXT_POS >= CTRL_W) begin : g_bad_bit
      $error("dll_phase_seq: control bit outside control word");
   end

   seq_state_t         st_q;
   logic [PHASE_W-1:0] ph_q;
   logic [PHASE_W-1:0] gray_w;
   logic               in_wait;
   logic               want_high;
   logic               matched;
   logic               tick;
   logic               expired;

   assign in_wait   = (st_q == S_WAIT_LOW) || (st_q == S_WAIT_HIGH);
   assign want_high = (st_q == S_WAIT_HIGH);
   assign matched   = in_wait && (gate_stat == want_high);
   assign busy      = (st_q != S_IDLE);

   us_prescaler #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_wait),
      .tick  (tick)
   );

   poll_limiter #(.LIMIT(POLL_LIMIT)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!in_wait),
      .tick    (tick),
      .expired (expired)
   );

   gray_enc #(.W(PHASE_W)) u_gray (
      .bin  (ph_q),
      .gray (gray_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         ph_q      <= '0;
         ctrl_word <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  ph_q                <= phase_idx;
                  ctrl_word[REC_POS]  <= 1'b0;
                  ctrl_word[GATE_POS] <= 1'b0;
                  ctrl_word[EXT_POS]  <= 1'b1;
                  ctrl_word[EN_POS]   <= 1'b1;
                  st_q                <= S_WAIT_LOW;
               end
            end
            S_WAIT_LOW: begin
               if (matched) begin
                  st_q <= S_LOAD;
               end else if (expired) begin
                  done <= 1'b1;
                  err  <= 1'b1;
                  st_q <= S_IDLE;
               end
            end
            S_LOAD: begin
               ctrl_word[SEL_LSB +: PHASE_W] <= gray_w;
               st_q <= S_REGATE;
            end
            S_REGATE: begin
               ctrl_word[GATE_POS] <= 1'b1;
               st_q <= S_WAIT_HIGH;
            end
            S_WAIT_HIGH: begin
               if (matched) begin
                  ctrl_word[REC_POS] <= 1'b1;
                  ctrl_word[EXT_POS] <= 1'b0;
                  done <= 1'b1;
                  st_q <= S_IDLE;
               end else if (expired) begin
                  done <= 1'b1;
                  err  <= 1'b1;
                  st_q <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dll_phase_seq_chk.sv
module dll_phase_seq_chk #(
   parameter int PHASE_W  = 4,
   parameter int CTRL_W   = 32,
   parameter int SEL_LSB  = 20,
   parameter int EN_POS   = 0,
   parameter int REC_POS  = 1,
   parameter int GATE_POS = 2,
   parameter int EXT_POS  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              gate_stat,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              busy,
   input logic              done,
   input logic              err
);
   localparam logic [CTRL_W-1:0] SEL_MASK = ((CTRL_W'(1) << PHASE_W) - 1'b1) << SEL_LSB;
   localparam logic [CTRL_W-1:0] USED_MASK = SEL_MASK |
      (CTRL_W'(1) << EN_POS) | (CTRL_W'(1) << REC_POS) |
      (CTRL_W'(1) << GATE_POS) | (CTRL_W'(1) << EXT_POS);

   // R2
   step1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctrl_word[EXT_POS] && ctrl_word[EN_POS] &&
                       !ctrl_word[GATE_POS] && !ctrl_word[REC_POS]));

   // R5
   sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_word & SEL_MASK) |-> !ctrl_word[GATE_POS]);

   // R6
   handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (ctrl_word[REC_POS] && !ctrl_word[EXT_POS] &&
                          ctrl_word[GATE_POS]));

   // R7
   timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> $stable(ctrl_word));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R7
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R9
   spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word & ~USED_MASK) == '0);
endmodule

bind dll_phase_seq dll_phase_seq_chk #(
   .PHASE_W(PHASE_W), .CTRL_W(CTRL_W), .SEL_LSB(SEL_LSB),
   .EN_POS(EN_POS), .REC_POS(REC_POS), .GATE_POS(GATE_POS), .EXT_POS(EXT_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .gate_stat(gate_stat),
   .ctrl_word(ctrl_word), .busy(busy), .done(done), .err(err)
);

// File: tb/dll_phase_seq_bench.sv
module dll_phase_seq_bench;
   localparam int DIV = 4;
   localparam int LIM = 6;
   localparam logic [31:0] EN = 32'h1, REC = 32'h2, GATE = 32'h4, EXT = 32'h8;
   // {phase index, expected reflected Gray code}
   localparam int NV = 8;
   localparam logic [7:0] VEC [NV] = '{8'h00, 8'hF8, 8'h57, 8'hAF,
                                       8'h74, 8'h8C, 8'h32, 8'hCA};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  phase = '0;
   logic        gate_stat;
   logic [31:0] ctrl_word;
   logic        busy, done, err;
   logic [2:0]  pipe = '0;
   int          mode = 0;
   int          n_chk = 0, n_bad = 0;
   int          cyc = 0;
   bit          mon_en = 1'b0;
   int          viol = 0;
   logic [3:0]  prev_sel = '0;

   always #10 clk = ~clk;

   dll_phase_seq #(.TICK_DIV(DIV), .POLL_LIMIT(LIM)) u_dll_phase_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_idx(phase),
      .gate_stat(gate_stat), .ctrl_word(ctrl_word), .busy(busy),
      .done(done), .err(err));

   always @(posedge clk) begin
      pipe <= {pipe[1:0], ctrl_word[2]};
      cyc  <= cyc + 1;
   end

   always_comb begin
      if (mode == 1)      gate_stat = 1'b1;
      else if (mode == 2) gate_stat = 1'b0;
      else                gate_stat = pipe[2];
   end

   // R5 monitor: select must not move while gate bit is 1
   always @(negedge clk) begin
      if (mon_en && ctrl_word[23:20] != prev_sel && ctrl_word[2]) viol = viol + 1;
      prev_sel = ctrl_word[23:20];
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic launch(input logic [3:0] p);
      @(negedge clk);
      phase = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 1;
      while (!done && n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      wait (cyc > 100000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int n;
      logic [31:0] exp;
      logic [3:0]  last_g;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ctrl_word == 0, "R1 ctrl", ctrl_word, 0);
      check(busy == 0, "R1 busy", 32'(busy), 0);
      check(done == 0, "R1 done", 32'(done), 0);
      check(err == 0, "R1 err", 32'(err), 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      last_g = 4'h0;

      for (int v = 0; v < NV; v++) begin
         launch(VEC[v][7:4]);
         // R2 first update, select still old
         exp = (32'(last_g) << 20) | EN | EXT;
         check(ctrl_word == exp, "R2 step1", ctrl_word, exp);
         wait_done(n);
         check(done && !err, "R6 done/err", {30'b0, done, err}, 32'h2);
         // R4 R6 R9 final word
         exp = (32'(VEC[v][3:0]) << 20) | EN | REC | GATE;
         check(ctrl_word == exp, "R4 R6 R9 final word", ctrl_word, exp);
         last_g = VEC[v][3:0];
      end

      // R3 R7: status stuck high, timeout in first wait
      mode = 1;
      launch(4'd9);
      wait_done(n);
      check(err == 1, "R7 err first wait", 32'(err), 1);
      check(n == LIM * DIV + 1, "R7 timeout cycle first wait", n, LIM * DIV + 1);
      exp = (32'(last_g) << 20) | EN | EXT;
      check(ctrl_word == exp, "R3 select kept on timeout", ctrl_word, exp);
      @(negedge clk);
      check(busy == 0, "R7 idle after timeout", 32'(busy), 0);
      mode = 0;
      repeat (5) @(negedge clk);

      launch(4'd9);
      wait_done(n);
      exp = (32'hD << 20) | EN | REC | GATE;
      check(ctrl_word == exp && !err, "R4 recovery after timeout", ctrl_word, exp);

      // R7: status stuck low, timeout in second wait
      mode = 2;
      launch(4'd6);
      wait_done(n);
      check(err == 1, "R7 err second wait", 32'(err), 1);
      check(n == LIM * DIV + 4, "R7 timeout cycle second wait", n, LIM * DIV + 4);
      exp = (32'h5 << 20) | EN | EXT | GATE;
      check(ctrl_word == exp, "R7 word held at timeout", ctrl_word, exp);
      mode = 0;
      repeat (5) @(negedge clk);

      // R8: start while busy is ignored
      launch(4'd2);
      phase = 4'd11;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(n);
      exp = (32'h3 << 20) | EN | REC | GATE;
      check(ctrl_word == exp, "R8 busy start ignored", ctrl_word, exp);
      repeat (20) @(negedge clk);
      check(busy == 0 && ctrl_word == exp, "R8 no second sequence", ctrl_word, exp);

      check(viol == 0, "R5 select only while gate off", viol, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule